// File: doc/BRIEF.md
# Static Memory Bus Bridge

This block connects a single-master internal request bus to one external asynchronous static memory port (NOR flash, PSRAM or SRAM). A request carries a byte address, a transfer size of one, two or four bytes, a direction and, for writes, right-justified data. The bridge checks that the address lies in its 256 MB window and picks one of four 64 MB sub-regions, each with its own active-low chip select. The external address, data, strobe and byte-lane lines are shared by all four sub-regions.

A static input selects an 8-bit or a 16-bit device. The byte address is shifted onto the external address pins to suit that width. A request wider than the device becomes a run of device-width external cycles, lowest address first. Read pieces are gathered into one result before the response is given. Two static counts set the address-setup and data-strobe lengths of each external cycle.

Top module: `smc_bridge`

## Requirements
- R1: An access in 0x6000_0000–0x6FFF_FFFF is served. Address bits [27:26] = k drive `mem_cs_n[k]` low for the whole access, so 0x6000_0000→bit 0, 0x6400_0000→bit 1, 0x6800_0000→bit 2 and 0x6C00_0000→bit 3.
- R2: At most one chip-select bit is low at any time. All are high while no access is running.
- R3: With `cfg_wide`=0 (8-bit device), `mem_addr` carries byte-address bits [25:0] of the current piece. Write data is placed on `mem_dout[7:0]` with `mem_dout[15:8]`=0, and read data is taken from `mem_din[7:0]`.
- R4: With `cfg_wide`=1 (16-bit device), `mem_addr[24:0]` carries byte-address bits [25:1] and `mem_addr[25]` is 0. Data uses all 16 lines.
- R5: A transfer wider than the device is split into back-to-back external cycles. For an 8-bit device a word takes 4 cycles and a halfword 2; for a 16-bit device a word takes 2. The cycles run in ascending address order from the address rounded down to the transfer size, least significant piece first.
- R6: Read data on `bus_rdata` is right-justified with unused upper bits 0. The piece from cycle b fills the next bits up. A byte read from a 16-bit device takes `mem_din[7:0]` for an even address and `mem_din[15:8]` for an odd one.
- R7: Each external cycle has a setup phase of max(1,`cfg_setup`) clocks, with chip select low and both strobes high. A data phase of max(1,`cfg_data`) clocks follows: `mem_oe_n` is low for a read, or `mem_we_n` low with `mem_dq_oe` high for a write. Read data is sampled on the last data clock. Chip select stays low from the first cycle of a transfer to the last.
- R8: `bus_ready` is high when idle, and a request is taken on a clock edge where `bus_valid` and `bus_ready` are both high. `bus_ready` is then low until the last external cycle ends. The next clock has `bus_ready` high and a one-clock `bus_resp` pulse. `bus_valid` is ignored while `bus_ready` is low.
- R9: An access outside the window asserts no chip select and starts no external cycle. It is answered on the next clock with `bus_resp` and `bus_err` both high.
- R10: `mem_bl_n` are active-low byte-lane enables: bit 0 for `mem_dout[7:0]` and bit 1 for `mem_dout[15:8]`. A byte access to a 16-bit device enables only the lane given by address bit 0. Halfword and word accesses enable both lanes. With an 8-bit device the enables are 2'b10.
- R11: A byte write to a 16-bit device drives the byte on both data lanes. Upper write-data bits beyond the transfer size have no effect.
- R12: A synchronous active-high `rst` returns the block to idle. Chip selects and strobes are high, `mem_dq_oe` is 0, `bus_ready` is 1 and `bus_resp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Right-justified write data |
| bus_ready | output | 1 | Bridge can take a request |
| bus_resp | output | 1 | One-clock completion pulse |
| bus_err | output | 1 | Completion was an out-of-window error |
| bus_rdata | output | DATA_W | Assembled read data, valid with bus_resp |
| cfg_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| cfg_setup | input | CNT_W | Setup clocks per external cycle (0 acts as 1) |
| cfg_data | input | CNT_W | Strobe clocks per external cycle (0 acts as 1) |
| mem_cs_n | output | NUM_CS | Active-low chip selects, one per sub-region |
| mem_addr | output | MEM_AW | External address |
| mem_dout | output | MEM_DW | External write data |
| mem_dq_oe | output | 1 | Data bus driven by the bridge |
| mem_din | input | MEM_DW | External read data |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_bl_n | output | 2 | Active-low byte-lane enables |

## Verification
The bench aims at the places where the address remap and the split interact. These include an unaligned word on an 8-bit device, which must start at the rounded-down address, and an odd byte on a 16-bit device. A bridge that skipped the rounding, left out the one-bit address shift or picked the wrong lane would write memory bytes the model can see, or return the neighbouring byte. Zero timing counts and exact response latency catch off-by-one phase counters. Addresses just outside the window and a second request raised while busy catch a decode that leaks a chip select, or a bridge that starts a second transfer.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_DATA  = 2'd2
  } smc_state_e;

  // index of the final device-width piece of a transfer
  function automatic logic [1:0] last_piece(input logic wide, input logic [1:0] size);
    if (wide) return size[1] ? 2'd1 : 2'd0;
    return size[1] ? 2'd3 : (size[0] ? 2'd1 : 2'd0);
  endfunction

endpackage

// File: rtl/smc_decode.sv
module smc_decode #(
  parameter int          ADDR_W  = 32,
  parameter int          NUM_CS  = 4,
  parameter int          SUB_LSB = 26,
  parameter logic [3:0]  REGION  = 4'h6
) (
  input  logic [ADDR_W-1:SUB_LSB] addr_hi,
  output logic                    hit,
  output logic [NUM_CS-1:0]       sel
);
  localparam int SEL_W = $clog2(NUM_CS);

  assign hit = (addr_hi[ADDR_W-1 -: 4] == REGION);

  for (genvar k = 0; k < NUM_CS; k++) begin : g_sel
    assign sel[k] = hit && (addr_hi[SUB_LSB +: SEL_W] == SEL_W'(k));
  end
endmodule

// File: rtl/smc_beat.sv
module smc_beat #(
  parameter int MEM_AW = 26,
  parameter int MEM_DW = 16,
  parameter int DATA_W = 32
) (
  input  logic              wide,
  input  logic [1:0]        size,
  input  logic [MEM_AW-1:0] addr,
  input  logic [1:0]        beat,
  input  logic [DATA_W-1:0] wdata,
  output logic [MEM_AW-1:0] ext_addr,
  output logic [MEM_DW-1:0] ext_dout,
  output logic [1:0]        ext_bl_n
);
  localparam int LANE_W = MEM_DW / 2;
  localparam int SH_W   = $clog2(DATA_W);

  logic [MEM_AW-1:0] base, ba;
  logic [SH_W-1:0]   sh;
  logic [DATA_W-1:0] wsh;

  always_comb begin
    base = addr & ~((MEM_AW'(1) << size) - MEM_AW'(1));
    ba   = base + (MEM_AW'(beat) << wide);
    sh   = wide ? SH_W'({beat[0], 4'b0000}) : SH_W'({beat, 3'b000});
    wsh  = wdata >> sh;
    if (!wide) begin
      ext_addr = ba;
      ext_dout = {{LANE_W{1'b0}}, wsh[LANE_W-1:0]};
      ext_bl_n = 2'b10;
    end else if (size == 2'd0) begin
      ext_addr = {1'b0, ba[MEM_AW-1:1]};
      ext_dout = {wdata[LANE_W-1:0], wdata[LANE_W-1:0]};
      ext_bl_n = ba[0] ? 2'b01 : 2'b10;
    end else begin
      ext_addr = {1'b0, ba[MEM_AW-1:1]};
      ext_dout = wsh[MEM_DW-1:0];
      ext_bl_n = 2'b00;
    end
  end
endmodule

// File: rtl/smc_rdmerge.sv
module smc_rdmerge #(
  parameter int MEM_DW = 16,
  parameter int DATA_W = 32
) (
  input  logic              wide,
  input  logic [1:0]        size,
  input  logic              lane,
  input  logic [1:0]        beat,
  input  logic [MEM_DW-1:0] din,
  output logic [DATA_W-1:0] piece
);
  localparam int LANE_W = MEM_DW / 2;
  localparam int SH_W   = $clog2(DATA_W);

  logic [SH_W-1:0] sh;

  always_comb begin
    sh = wide ? SH_W'({beat[0], 4'b0000}) : SH_W'({beat, 3'b000});
    if (!wide)
      piece = DATA_W'(din[LANE_W-1:0]) << sh;
    else if (size == 2'd0)
      piece = DATA_W'(lane ? din[MEM_DW-1:LANE_W] : din[LANE_W-1:0]);
    else
      piece = DATA_W'(din) << sh;
  end
endmodule

// File: rtl/smc_bridge.sv
module smc_bridge
  import smc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MEM_AW = 26,
  parameter int MEM_DW = 16,
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic              bus_resp,
  output logic              bus_err,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cfg_wide,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_data,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [MEM_DW-1:0] mem_dout,
  output logic              mem_dq_oe,
  input  logic [MEM_DW-1:0] mem_din,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [1:0]        mem_bl_n
);
  logic              dec_hit;
  logic [NUM_CS-1:0] dec_sel;

  smc_decode #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .SUB_LSB(MEM_AW), .REGION(4'h6)) u_dec (
    .addr_hi(bus_addr[ADDR_W-1:MEM_AW]), .hit(dec_hit), .sel(dec_sel)
  );

  // held request
  smc_state_e        st, st_n;
  logic [1:0]        beat, beat_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [DATA_W-1:0] acc, acc_n;
  logic              r_wr, n_wr, r_wide, n_wide;
  logic [1:0]        r_size, n_size;
  logic [MEM_AW-1:0] r_addr, n_addr;
  logic [DATA_W-1:0] r_wdata, n_wdata;
  logic [NUM_CS-1:0] r_sel, n_sel;
  logic              fin, err_n;
  logic [CNT_W-1:0]  setup_eff, data_eff;
  logic [DATA_W-1:0] rd_piece;
  logic [MEM_AW-1:0] nb_addr;
  logic [MEM_DW-1:0] nb_dout;
  logic [1:0]        nb_bl_n;

  assign setup_eff = (cfg_setup == '0) ? CNT_W'(1) : cfg_setup;
  assign data_eff  = (cfg_data  == '0) ? CNT_W'(1) : cfg_data;

  smc_rdmerge #(.MEM_DW(MEM_DW), .DATA_W(DATA_W)) u_merge (
    .wide(r_wide), .size(r_size), .lane(r_addr[0]), .beat(beat),
    .din(mem_din), .piece(rd_piece)
  );

  always_comb begin
    st_n = st; beat_n = beat; cnt_n = cnt; acc_n = acc;
    n_wr = r_wr; n_wide = r_wide; n_size = r_size; n_addr = r_addr;
    n_wdata = r_wdata; n_sel = r_sel;
    fin = 1'b0; err_n = 1'b0;
    unique case (st)
      ST_IDLE: if (bus_valid) begin
        if (!dec_hit) begin
          fin = 1'b1; err_n = 1'b1;
        end else begin
          st_n = ST_SETUP; beat_n = '0; cnt_n = CNT_W'(1); acc_n = '0;
          n_wr = bus_write; n_wide = cfg_wide; n_addr = bus_addr[MEM_AW-1:0];
          n_size = bus_size[1] ? 2'd2 : bus_size;
          n_wdata = bus_wdata; n_sel = dec_sel;
        end
      end
      ST_SETUP: begin
        if (cnt >= setup_eff) begin st_n = ST_DATA; cnt_n = CNT_W'(1); end
        else cnt_n = cnt + CNT_W'(1);
      end
      ST_DATA: begin
        if (cnt >= data_eff) begin
          if (!r_wr) acc_n = acc | rd_piece;
          if (beat == last_piece(r_wide, r_size)) begin
            st_n = ST_IDLE; fin = 1'b1;
          end else begin
            st_n = ST_SETUP; beat_n = beat + 2'd1; cnt_n = CNT_W'(1);
          end
        end else cnt_n = cnt + CNT_W'(1);
      end
      default: st_n = ST_IDLE;
    endcase
  end

  smc_beat #(.MEM_AW(MEM_AW), .MEM_DW(MEM_DW), .DATA_W(DATA_W)) u_beat (
    .wide(n_wide), .size(n_size), .addr(n_addr), .beat(beat_n), .wdata(n_wdata),
    .ext_addr(nb_addr), .ext_dout(nb_dout), .ext_bl_n(nb_bl_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; beat <= '0; cnt <= '0; acc <= '0;
      r_wr <= 1'b0; r_wide <= 1'b0; r_size <= '0; r_addr <= '0; r_wdata <= '0; r_sel <= '0;
      mem_cs_n <= '1; mem_addr <= '0; mem_dout <= '0; mem_dq_oe <= 1'b0;
      mem_oe_n <= 1'b1; mem_we_n <= 1'b1; mem_bl_n <= '1;
      bus_ready <= 1'b1; bus_resp <= 1'b0; bus_err <= 1'b0; bus_rdata <= '0;
    end else begin
      st <= st_n; beat <= beat_n; cnt <= cnt_n; acc <= acc_n;
      r_wr <= n_wr; r_wide <= n_wide; r_size <= n_size; r_addr <= n_addr;
      r_wdata <= n_wdata; r_sel <= n_sel;
      mem_cs_n  <= (st_n != ST_IDLE) ? ~n_sel : '1;
      mem_addr  <= (st_n != ST_IDLE) ? nb_addr : '0;
      mem_dout  <= (st_n != ST_IDLE && n_wr) ? nb_dout : '0;
      mem_bl_n  <= (st_n != ST_IDLE) ? nb_bl_n : '1;
      mem_oe_n  <= !(st_n == ST_DATA && !n_wr);
      mem_we_n  <= !(st_n == ST_DATA && n_wr);
      mem_dq_oe <= (st_n == ST_DATA && n_wr);
      bus_ready <= (st_n == ST_IDLE);
      bus_resp  <= fin;
      bus_err   <= err_n;
      if (fin) bus_rdata <= err_n ? '0 : acc_n;
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(~mem_cs_n)); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(!mem_oe_n && !mem_we_n)); // R7
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1)); // R7
  AST_DQ_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst) mem_dq_oe |-> !mem_we_n); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr)); // R7
  AST_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
    (mem_cs_n != '1) |-> !bus_ready); // R8
  AST_RESP_READY: assert property (@(posedge clk) disable iff (rst) bus_resp |-> bus_ready); // R8
  AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (rst)
    (bus_resp && bus_err) |-> (mem_cs_n == '1 && mem_oe_n && mem_we_n)); // R9
endmodule

// File: tb/tb_smc_bridge.sv
module tb_smc_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic        bus_ready, bus_resp, bus_err;
  logic [31:0] bus_rdata;
  logic        cfg_wide = 1'b1;
  logic [3:0]  cfg_setup = 4'd1, cfg_data = 4'd1;
  logic [3:0]  mem_cs_n;
  logic [25:0] mem_addr;
  logic [15:0] mem_dout, mem_din;
  logic        mem_dq_oe, mem_oe_n, mem_we_n;
  logic [1:0]  mem_bl_n;

  always #5 clk = ~clk;

  smc_bridge dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_resp(bus_resp),
    .bus_err(bus_err), .bus_rdata(bus_rdata), .cfg_wide(cfg_wide), .cfg_setup(cfg_setup),
    .cfg_data(cfg_data), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dq_oe(mem_dq_oe), .mem_din(mem_din), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bl_n(mem_bl_n)
  );

  int errors = 0, checks = 0;
  logic [7:0] emem [0:1023];

  // external device model
  always_comb begin
    if (cfg_wide) mem_din = {emem[{mem_addr[8:0], 1'b1}], emem[{mem_addr[8:0], 1'b0}]};
    else          mem_din = {8'h00, emem[mem_addr[9:0]]};
  end

  int cs_cycles, strobe_cycles, beats, multi_cs;
  logic prev_strobe;
  logic [3:0]  cs_seen;
  logic [25:0] a_log [0:7];
  logic [15:0] d_log [0:7];
  logic [1:0]  bl_log [0:7];

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_cs_n != 4'hF) begin
        cs_cycles++; cs_seen = mem_cs_n;
        if ($countones(~mem_cs_n) != 1) multi_cs++;
      end
      if (!mem_oe_n || !mem_we_n) begin
        strobe_cycles++;
        if (!prev_strobe) begin
          if (beats < 8) begin
            a_log[beats] = mem_addr; d_log[beats] = mem_dout; bl_log[beats] = mem_bl_n;
          end
          beats++;
        end
      end
      prev_strobe = !mem_oe_n || !mem_we_n;
      if (!mem_we_n && mem_dq_oe) begin
        if (cfg_wide) begin
          if (!mem_bl_n[0]) emem[{mem_addr[8:0], 1'b0}] = mem_dout[7:0];
          if (!mem_bl_n[1]) emem[{mem_addr[8:0], 1'b1}] = mem_dout[15:8];
        end else emem[mem_addr[9:0]] = mem_dout[7:0];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    cs_cycles = 0; strobe_cycles = 0; beats = 0; prev_strobe = 1'b0; cs_seen = 4'hF;
  endtask

  int lat, rdy_bad;
  logic [31:0] rd;
  logic        er;

  task automatic xfer(input logic wr, input logic [31:0] addr, input logic [1:0] size,
                      input logic [31:0] wd);
    @(negedge clk);
    clear_mon();
    bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_size = size; bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0;
    lat = 1; rdy_bad = 0;
    while (!bus_resp && lat < 1000) begin
      if (bus_ready) rdy_bad++;
      @(negedge clk);
      lat++;
    end
    rd = bus_rdata; er = bus_err;
  endtask

  task automatic t_reset();
    chk("R12 ready", {31'b0, bus_ready}, 32'd1);
    chk("R12 cs_n", {28'b0, mem_cs_n}, 32'hF);
    chk("R12 strobes", {30'b0, mem_oe_n, mem_we_n}, 32'd3);
    chk("R12 dq_oe/resp", {30'b0, mem_dq_oe, bus_resp}, 32'd0);
  endtask

  task automatic t_wide_word();
    cfg_wide = 1'b1; cfg_setup = 4'd2; cfg_data = 4'd3;
    xfer(1'b1, 32'h6000_0010, 2'd2, 32'hA1B2_C3D4);
    chk("R5 wide word beats", beats, 2);
    chk("R4 addr beat0", {6'b0, a_log[0]}, 32'h8);
    chk("R4 addr beat1", {6'b0, a_log[1]}, 32'h9);
    chk("R5 data beat0", {16'b0, d_log[0]}, 32'hC3D4);
    chk("R5 data beat1", {16'b0, d_log[1]}, 32'hA1B2);
    chk("R10 lanes word", {30'b0, bl_log[0]}, 32'd0);
    chk("R1 cs region0", {28'b0, cs_seen}, 32'hE);
    chk("R7 cs cycles", cs_cycles, 10);
    chk("R7 strobe cycles", strobe_cycles, 6);
    chk("R8 latency", lat, 11);
    chk("R8 ready low while busy", rdy_bad, 0);
    chk("R4 memory bytes", {emem[19], emem[18], emem[17], emem[16]}, 32'hA1B2_C3D4);
    xfer(1'b0, 32'h6000_0010, 2'd2, 32'h0);
    chk("R6 wide word read", rd, 32'hA1B2_C3D4);
    chk("R9 no err in window", {31'b0, er}, 32'd0);
  endtask

  task automatic t_narrow();
    cfg_wide = 1'b0; cfg_setup = 4'd1; cfg_data = 4'd1;
    xfer(1'b1, 32'h6400_0021, 2'd2, 32'h1122_3344);
    chk("R5 narrow word beats", beats, 4);
    chk("R5 aligned first addr", {6'b0, a_log[0]}, 32'h20);
    chk("R3 last addr", {6'b0, a_log[3]}, 32'h23);
    chk("R3 data beat0", {16'b0, d_log[0]}, 32'h0044);
    chk("R3 data beat3", {16'b0, d_log[3]}, 32'h0011);
    chk("R10 narrow lanes", {30'b0, bl_log[1]}, 32'd2);
    chk("R1 cs region1", {28'b0, cs_seen}, 32'hD);
    chk("R8 narrow latency", lat, 9);
    xfer(1'b0, 32'h6400_0020, 2'd2, 32'h0);
    chk("R6 narrow word read", rd, 32'h1122_3344);
    xfer(1'b0, 32'h6400_0022, 2'd1, 32'h0);
    chk("R5 narrow half beats", beats, 2);
    chk("R6 narrow half read", rd, 32'h0000_1122);
  endtask

  task automatic t_byte16();
    cfg_wide = 1'b1; cfg_setup = 4'd1; cfg_data = 4'd2;
    emem[64] = 8'h77; emem[65] = 8'h00;
    xfer(1'b1, 32'h6800_0041, 2'd0, 32'hFFFF_FF5A);
    chk("R10 byte beats", beats, 1);
    chk("R4 byte addr", {6'b0, a_log[0]}, 32'h20);
    chk("R10 odd byte lane", {30'b0, bl_log[0]}, 32'd1);
    chk("R11 byte replicated", {16'b0, d_log[0]}, 32'h5A5A);
    chk("R1 cs region2", {28'b0, cs_seen}, 32'hB);
    chk("R11 odd byte written", {24'b0, emem[65]}, 32'h5A);
    chk("R10 even byte untouched", {24'b0, emem[64]}, 32'h77);
    xfer(1'b0, 32'h6800_0040, 2'd0, 32'h0);
    chk("R6 even byte read", rd, 32'h77);
    xfer(1'b0, 32'h6800_0041, 2'd0, 32'h0);
    chk("R6 odd byte read", rd, 32'h5A);
    xfer(1'b0, 32'h6800_0040, 2'd1, 32'h0);
    chk("R6 half read", rd, 32'h5A77);
  endtask

  task automatic t_error();
    xfer(1'b0, 32'h7000_0000, 2'd2, 32'h0);
    chk("R9 err above", {31'b0, er}, 32'd1);
    chk("R9 latency above", lat, 1);
    chk("R9 no cs above", cs_cycles, 0);
    xfer(1'b1, 32'h5FFF_FFFC, 2'd2, 32'hDEAD_BEEF);
    chk("R9 err below", {31'b0, er}, 32'd1);
    chk("R9 no strobe below", beats, 0);
  endtask

  task automatic t_region3();
    cfg_wide = 1'b1; cfg_setup = 4'd1; cfg_data = 4'd1;
    emem[4] = 8'h01; emem[5] = 8'h02; emem[6] = 8'h03; emem[7] = 8'h04;
    xfer(1'b0, 32'h6C00_0004, 2'd2, 32'h0);
    chk("R1 cs region3", {28'b0, cs_seen}, 32'h7);
    chk("R6 region3 read", rd, 32'h0403_0201);
    chk("R2 single cs", multi_cs, 0);
  endtask

  task automatic t_zero_cfg();
    cfg_wide = 1'b1; cfg_setup = 4'd0; cfg_data = 4'd0;
    xfer(1'b0, 32'h6000_0000, 2'd0, 32'h0);
    chk("R7 zero cfg latency", lat, 3);
    chk("R7 zero cfg strobe", strobe_cycles, 1);
    chk("R7 zero cfg cs", cs_cycles, 2);
  endtask

  task automatic t_busy();
    cfg_wide = 1'b1; cfg_setup = 4'd2; cfg_data = 4'd2;
    emem[512] = 8'h00; emem[513] = 8'h00;
    @(negedge clk);
    clear_mon();
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 32'h6000_0100; bus_size = 2'd1;
    bus_wdata = 32'h0000_BEEF;
    @(negedge clk);
    bus_addr = 32'h6000_0200; bus_wdata = 32'h0000_DEAD;
    @(negedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    lat = 0;
    while (!bus_resp && lat < 1000) begin @(negedge clk); lat++; end
    repeat (6) @(negedge clk);
    chk("R8 one beat only", beats, 1);
    chk("R8 held write", {16'b0, emem[257], emem[256]}, 32'hBEEF);
    chk("R8 busy request ignored", {16'b0, emem[513], emem[512]}, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) emem[i] = 8'h00;
    multi_cs = 0;
    clear_mon();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_wide_word();
    t_narrow();
    t_byte16();
    t_error();
    t_region3();
    t_zero_cfg();
    t_busy();
    chk("R2 single cs overall", multi_cs, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule